// File: doc/BRIEF.md
# Write Buffer With Read Bypass

This block holds stores on their way from a cache to a slower memory. Write-through stores and dirty lines evicted by the cache enter a small queue. A single memory port drains the queue one transaction at a time, oldest entry first. The cache can therefore retire stores without waiting for memory.

A read miss does not wait for the queue to empty. When the block accepts a read, it compares the read address with every queued entry and with the write already on the memory port. If an entry matches, the block answers the read one cycle later with the newest buffered copy and sends nothing to memory. If nothing matches, the read takes the memory port before any queued write. A dirty victim line offered together with a read is parked in the queue during the same cycle, so the fill read reaches memory before the victim is written back. A store to an address that is already queued overwrites that entry in place, so the lookup never finds two matches.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset, `wr_full`, `mem_req` and `rd_resp_valid` are low and `rd_ready` is high.
- R2: With no read waiting, queued writes go to memory in acceptance order, one write per memory transaction (`mem_we`=1).
- R3: When all DEPTH entries are occupied, `wr_full` is high and a presented write is not accepted until an entry frees.
- R4: A write whose address matches a queued entry that is not being popped that cycle replaces that entry's data. No new entry is taken, and memory receives only the latest data, once.
- R5: A read whose address matches no queued or in-flight write is issued on the memory port (`mem_we`=0) as the next transaction, ahead of every queued write.
- R6: A read whose address matches a queued entry, or the write held on the memory port, is answered in the cycle after acceptance with the newest matching data. No memory read is issued for it.
- R7: A victim (`vic_valid` with an accepted read) is queued in the accept cycle. Its write-back reaches memory after the fill read.
- R8: A memory read completes on `mem_ack`. In the next cycle `rd_resp_valid` is high and `rd_resp_data` equals the `mem_rdata` sampled with the ack.
- R9: Once raised, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`.
- R10: A write accepted in the same cycle as a read to the same address is ordered after the read. The read goes to memory and the write follows it.
- R11: While `rd_valid` and `vic_valid` are both high, `wr_full` is high, so the victim owns the enqueue slot. While the queue is full, `rd_ready` is low for a read that carries a victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Store presented |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| wr_full | output | 1 | Store not accepted this cycle |
| rd_valid | input | 1 | Read miss presented |
| rd_addr | input | AW | Read miss address |
| vic_valid | input | 1 | Dirty victim accompanies the read |
| vic_addr | input | AW | Victim address |
| vic_data | input | DW | Victim data |
| rd_ready | output | 1 | Read (and victim) accepted when rd_valid is high |
| rd_resp_valid | output | 1 | Read data valid, one-cycle pulse |
| rd_resp_data | output | DW | Read data |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completes the transaction |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |

## Verification
The bench builds the block with DEPTH=4, AW=12 and DW=16. With only four entries, a memory model that can withhold its ack fills the queue in a few stores, so full-queue stalls, overwrite in place, and reads that overtake parked writes and victims can all be set up in short sequences. The narrow address keeps the read data the model computes from the address easy to predict in the scoreboard.

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic          vic_valid,
  input  logic [AW-1:0] vic_addr,
  input  logic [DW-1:0] vic_data,
  output logic          rd_ready,
  output logic          rd_resp_valid,
  output logic [DW-1:0] rd_resp_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  // DEPTH must be a power of two, at least 2
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] v;
  logic [AW-1:0]    a [DEPTH];
  logic [DW-1:0]    d [DEPTH];
  logic [PW-1:0]    head, tail, m_idx;
  logic [CW-1:0]    cnt;
  logic             rd_pend;
  logic [AW-1:0]    rd_addr_q;

  logic full, rd_busy, rd_go, wr_go, enq, issue_rd, pop;
  logic b_hit, h_hit, fwd_hit, m_hit;
  logic [DW-1:0] b_data, fwd_data, enq_data;
  logic [AW-1:0] enq_addr;

  assign full     = (cnt == CW'(DEPTH));
  assign rd_busy  = rd_pend | (mem_req & ~mem_we);
  assign rd_ready = ~rd_busy & ~(vic_valid & full);
  assign rd_go    = rd_valid & rd_ready;
  assign wr_full  = full | (rd_valid & vic_valid);
  assign wr_go    = wr_valid & ~wr_full;
  assign enq      = wr_go | (rd_go & vic_valid);
  assign enq_addr = wr_go ? wr_addr : vic_addr;
  assign enq_data = wr_go ? wr_data : vic_data;
  assign issue_rd = ~mem_req & rd_pend;
  assign pop      = ~mem_req & ~rd_pend & (cnt != '0);
  assign tail     = head + PW'(cnt);

  always_comb begin
    b_hit  = 1'b0;
    b_data = '0;
    m_hit  = 1'b0;
    m_idx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (v[i] && a[i] == rd_addr) begin
        b_hit  = 1'b1;
        b_data = d[i];
      end
      if (v[i] && a[i] == enq_addr && !(pop && PW'(i) == head)) begin
        m_hit = 1'b1;
        m_idx = PW'(i);
      end
    end
  end

  assign h_hit    = mem_req & mem_we & (mem_addr == rd_addr);
  assign fwd_hit  = b_hit | h_hit;
  assign fwd_data = b_hit ? b_data : mem_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v             <= '0;
      head          <= '0;
      cnt           <= '0;
      mem_req       <= 1'b0;
      mem_we        <= 1'b0;
      mem_addr      <= '0;
      mem_wdata     <= '0;
      rd_pend       <= 1'b0;
      rd_addr_q     <= '0;
      rd_resp_valid <= 1'b0;
      rd_resp_data  <= '0;
    end else begin
      rd_resp_valid <= 1'b0;
      if (mem_req && mem_ack) begin
        mem_req <= 1'b0;
        if (!mem_we) begin
          rd_resp_valid <= 1'b1;
          rd_resp_data  <= mem_rdata;
        end
      end
      if (issue_rd) begin
        mem_req  <= 1'b1;
        mem_we   <= 1'b0;
        mem_addr <= rd_addr_q;
        rd_pend  <= 1'b0;
      end else if (pop) begin
        mem_req   <= 1'b1;
        mem_we    <= 1'b1;
        mem_addr  <= a[head];
        mem_wdata <= d[head];
        v[head]   <= 1'b0;
        head      <= head + 1'b1;
      end
      if (rd_go) begin
        if (fwd_hit) begin
          rd_resp_valid <= 1'b1;
          rd_resp_data  <= fwd_data;
        end else begin
          rd_pend   <= 1'b1;
          rd_addr_q <= rd_addr;
        end
      end
      if (enq && !m_hit) v[tail] <= 1'b1;
      cnt <= cnt + CW'(enq && !m_hit) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (enq) begin
      if (m_hit) d[m_idx] <= enq_data;
      else begin
        a[tail] <= enq_addr;
        d[tail] <= enq_data;
      end
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r5_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && !mem_req) |=> (mem_req && !mem_we && mem_addr == $past(rd_addr_q)));

  a_r6_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && fwd_hit) |=> (rd_resp_valid && !rd_pend));

  a_r7_victim_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && vic_valid && !fwd_hit) |=> (rd_pend && cnt != '0));

  a_r8_fill_return: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (rd_resp_valid && rd_resp_data == $past(mem_rdata)));

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

// File: tb/wbuf_bypass_test.sv
module wbuf_bypass_test;
  localparam int AW = 12, DW = 16, LAT = 3;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, rd_valid = 0, vic_valid = 0, mem_ack = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0, vic_addr = '0;
  logic [DW-1:0] wr_data = '0, vic_data = '0, mem_rdata = '0;
  logic wr_full, rd_ready, rd_resp_valid, mem_req, mem_we;
  logic [DW-1:0] rd_resp_data, mem_wdata;
  logic [AW-1:0] mem_addr;

  int total = 0, bad = 0;
  bit stall = 0;
  int lat = 0;
  bit rsp_due = 0;
  logic [AW+DW:0] exp_mem [$];
  logic [DW-1:0]  exp_rsp [$];

  always #5 clk = ~clk;

  wbuf_bypass #(.AW(AW), .DW(DW), .DEPTH(4)) uut (.*);

  function automatic logic [DW-1:0] f(input logic [AW-1:0] x);
    return DW'(x) * 16'd3 + 16'd7;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic exp_w(input logic [AW-1:0] ad, input logic [DW-1:0] dt);
    exp_mem.push_back({1'b1, ad, dt});
  endtask
  task automatic exp_r(input logic [AW-1:0] ad);
    exp_mem.push_back({1'b0, ad, f(ad)});
    exp_rsp.push_back(f(ad));
  endtask

  // memory model and transaction monitor
  always @(negedge clk) begin
    if (rsp_due) begin
      chk(rd_resp_valid === 1'b1, "R8", "resp cycle after read ack", rd_resp_valid, 1);
      rsp_due = 0;
    end
    if (mem_ack) begin
      mem_ack = 0;
      lat = 0;
    end else if (rst_n && mem_req && !stall) begin
      lat++;
      if (lat == LAT) begin
        logic [AW+DW:0] got, e;
        mem_ack = 1;
        mem_rdata = f(mem_addr);
        got = {mem_we, mem_addr, mem_we ? mem_wdata : f(mem_addr)};
        if (exp_mem.size() == 0)
          chk(0, "R2", "unexpected memory transaction", got, 0);
        else begin
          e = exp_mem.pop_front();
          chk(got === e, "R2", "memory transaction {we,addr,data}", got, e);
        end
        if (!mem_we) rsp_due = 1;
      end
    end
  end

  // response monitor
  always @(negedge clk) begin
    if (rst_n && rd_resp_valid) begin
      if (exp_rsp.size() == 0)
        chk(0, "R6", "unexpected read response", rd_resp_data, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_rsp.pop_front();
        chk(rd_resp_data === e, "R6", "read response data", rd_resp_data, e);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] ad, input logic [DW-1:0] dt);
    wr_valid = 1; wr_addr = ad; wr_data = dt;
    while (wr_full) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rd(input logic [AW-1:0] ad, input bit vv,
                    input logic [AW-1:0] va, input logic [DW-1:0] vd);
    rd_valid = 1; rd_addr = ad; vic_valid = vv; vic_addr = va; vic_data = vd;
    #1;
    if (vv) chk(wr_full === 1'b1, "R11", "wr_full while victim offered", wr_full, 1);
    while (!rd_ready) @(negedge clk);
    @(negedge clk);
    rd_valid = 0; vic_valid = 0;
  endtask

  task automatic settle();
    while (exp_mem.size() != 0 || exp_rsp.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(wr_full === 1'b0, "R1", "wr_full", wr_full, 0);
    chk(mem_req === 1'b0, "R1", "mem_req", mem_req, 0);
    chk(rd_resp_valid === 1'b0, "R1", "rd_resp_valid", rd_resp_valid, 0);
    chk(rd_ready === 1'b1, "R1", "rd_ready", rd_ready, 1);
    rst_n = 1;
    @(negedge clk);

    // R2 plain drain in order
    exp_w(12'h100, 16'h1111); exp_w(12'h104, 16'h2222); exp_w(12'h108, 16'h3333);
    wr(12'h100, 16'h1111); wr(12'h104, 16'h2222); wr(12'h108, 16'h3333);
    settle();

    // R3 full and R9 hold
    stall = 1;
    exp_w(12'h200, 16'hA0);
    for (int i = 1; i <= 5; i++) exp_w(AW'(12'h200 + i), DW'(16'hA0 + i));
    wr(12'h200, 16'hA0);
    for (int i = 1; i <= 4; i++) wr(AW'(12'h200 + i), DW'(16'hA0 + i));
    chk(wr_full === 1'b1, "R3", "wr_full with four queued", wr_full, 1);
    fork
      wr(12'h205, 16'hA5);
      begin
        logic [AW-1:0] held;
        held = mem_addr;
        repeat (3) @(negedge clk);
        chk(wr_full === 1'b1, "R3", "write still stalled", wr_full, 1);
        chk(mem_req === 1'b1 && mem_addr === held, "R9", "request held until ack", mem_addr, held);
        stall = 0;
      end
    join
    settle();

    // R4 overwrite in place
    stall = 1;
    exp_w(12'h300, 16'h0D); exp_w(12'h310, 16'h0B2); exp_w(12'h320, 16'h0C);
    wr(12'h300, 16'h0D); wr(12'h310, 16'h0B1); wr(12'h320, 16'h0C); wr(12'h310, 16'h0B2);
    stall = 0;
    settle();

    // R5 read overtakes queued writes
    stall = 1;
    exp_w(12'h400, 16'h40); exp_r(12'h4F0); exp_w(12'h404, 16'h41); exp_w(12'h408, 16'h42);
    wr(12'h400, 16'h40); wr(12'h404, 16'h41); wr(12'h408, 16'h42);
    rd(12'h4F0, 0, '0, '0);
    chk(mem_addr === 12'h400, "R5", "in-flight write unchanged", mem_addr, 12'h400);
    stall = 0;
    settle();

    // R6 forwarding from queue and from in-flight write
    stall = 1;
    exp_w(12'h500, 16'h55); exp_w(12'h504, 16'h66);
    wr(12'h500, 16'h55); wr(12'h504, 16'h66);
    exp_rsp.push_back(16'h66);
    rd(12'h504, 0, '0, '0);
    chk(rd_resp_valid === 1'b1, "R6", "hit answered next cycle", rd_resp_valid, 1);
    exp_rsp.push_back(16'h55);
    rd(12'h500, 0, '0, '0);
    chk(rd_resp_valid === 1'b1, "R6", "in-flight hit answered next cycle", rd_resp_valid, 1);
    stall = 0;
    settle();

    // R7 victim parked, fill first
    stall = 1;
    exp_w(12'h600, 16'h60); exp_r(12'h6A0); exp_w(12'h6C0, 16'h6C);
    wr(12'h600, 16'h60);
    rd(12'h6A0, 1, 12'h6C0, 16'h6C);
    stall = 0;
    settle();

    // R10 same-cycle write and read to one address
    exp_r(12'h700); exp_w(12'h700, 16'h77);
    wr_valid = 1; wr_addr = 12'h700; wr_data = 16'h77;
    rd_valid = 1; rd_addr = 12'h700;
    #1;
    chk(rd_ready === 1'b1 && wr_full === 1'b0, "R10", "both accepted", {rd_ready, wr_full}, 2'b10);
    @(negedge clk);
    wr_valid = 0; rd_valid = 0;
    settle();

    chk(exp_mem.size() == 0, "R2", "memory queue drained", exp_mem.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule